// File: doc/BRIEF.md
# Five-Tuple Hashed Flow Lookup

This block resolves an IPv4 five-tuple (source address, destination address, source port, destination port, protocol) to a forwarding decision. The tuple is hashed to choose a bucket in a primary flow table. When the bucket entry holds a different tuple, a hint stored in that entry points into a separate overflow table, and the walk follows the hints until it finds the tuple, reaches the end of the chain, or uses up its hop budget.

A hit returns the flow's session ID and next hop. A miss returns no session and a next hop taken from a configuration input, normally the CPU redirect path. Software programs both tables through one write port. Entries for the two directions of a connection are separate keys in the same tables. One lookup is in flight at a time. Requests use a valid/ready handshake, and each result is a one-cycle pulse with a hit flag.

Top module: `flow_lookup`

## Requirements
- R1: After reset `req_ready_o` is 1, `res_valid_o` is 0, and every entry of both tables is invalid, so any lookup misses.
- R2: When the primary bucket entry is valid and holds the request tuple, the result has `res_hit_o`=1 and that entry's session ID and next hop. `res_valid_o` is high for exactly one cycle, in the cycle after the first clock edge that follows the accepting edge. A primary match wins even when the entry's hint is nonzero.
- R3: The bucket index is the low log2(PRI_DEPTH) bits of a CRC-16. The CRC uses polynomial 0x1021, initial value 0xFFFF, no reflection and no final XOR. It runs MSB first over the 104-bit key {src_ip[31:0], dst_ip[31:0], src_port[15:0], dst_port[15:0], proto[7:0]}. `wr_key_i` uses the same layout.
- R4: When a valid entry does not match and its hint h is nonzero, the walk reads overflow entry h next. A match at the n-th overflow entry returns that entry's fields n clock edges after the edge where a primary hit would have been reported.
- R5: A non-matching entry whose hint is 0 ends the walk with a miss. So does an invalid entry, whatever hint it holds.
- R6: The walk visits at most MAX_HOPS overflow entries. When the last of these does not match, the result is a miss, even if that entry's hint is nonzero.
- R7: A miss gives `res_hit_o`=0, `res_sid_o`=0, and `res_nh_o` equal to `miss_nh_i`.
- R8: `req_ready_o` is 0 from the accepting edge until the cycle after the result pulse. Requests presented during that time are ignored and produce no result.
- R9: An entry written with `wr_valid_i`=0 never matches, even when its key equals the request tuple.
- R10: A tuple and its reversed tuple (addresses swapped and ports swapped) can both be installed at once. Each looks up to its own session.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request valid |
| req_ready_o | output | 1 | Block idle, request accepted on this edge |
| req_src_ip_i | input | 32 | Source IPv4 address |
| req_dst_ip_i | input | 32 | Destination IPv4 address |
| req_src_port_i | input | 16 | Source L4 port |
| req_dst_port_i | input | 16 | Destination L4 port |
| req_proto_i | input | 8 | IP protocol |
| miss_nh_i | input | NH_W | Next hop returned on a miss |
| wr_en_i | input | 1 | Table write strobe |
| wr_ovf_i | input | 1 | 0 writes the primary table, 1 writes the overflow table |
| wr_addr_i | input | ADDR_W | Bucket or overflow index |
| wr_valid_i | input | 1 | Valid bit of the written entry |
| wr_key_i | input | 104 | Entry key (R3 layout) |
| wr_sid_i | input | SID_W | Entry session ID |
| wr_nh_i | input | NH_W | Entry next hop |
| wr_hint_i | input | HINT_W | Overflow index of the next entry, 0 ends the chain |
| res_valid_o | output | 1 | Result pulse |
| res_hit_o | output | 1 | 1 on hit, 0 on miss |
| res_sid_o | output | SID_W | Session ID |
| res_nh_o | output | NH_W | Next hop |

## Verification
The bench uses the default 256-bucket primary table and a full 8-bit hint space, but lowers MAX_HOPS to 2. With that bound, a three-deep overflow chain holding the tuple in its last link shows the bound cutting the walk short (R6). Keeping the wide CRC index lets the bench find each bucket with its own CRC model and place colliding decoy keys there on purpose. It also keeps a tuple and its reverse apart unless they actually share a bucket.

// File: rtl/flow_lookup_pkg.sv
package flow_lookup_pkg;
  localparam int IP_W    = 32;
  localparam int PORT_W  = 16;
  localparam int PROTO_W = 8;
  localparam int KEY_W   = 2*IP_W + 2*PORT_W + PROTO_W;
  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_INIT = 16'hFFFF;

  typedef struct packed {
    logic [IP_W-1:0]    src_ip;
    logic [IP_W-1:0]    dst_ip;
    logic [PORT_W-1:0]  src_port;
    logic [PORT_W-1:0]  dst_port;
    logic [PROTO_W-1:0] proto;
  } key_t;

  typedef enum logic [1:0] {ST_IDLE, ST_PRI, ST_OVF, ST_DONE} walk_st_e;

  function automatic logic [15:0] crc16(input logic [KEY_W-1:0] k);
    logic [15:0] c;
    logic fb;
    c = CRC_INIT;
    for (int i = KEY_W-1; i >= 0; i--) begin
      fb = c[15] ^ k[i];
      c  = {c[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
    end
    return c;
  endfunction
endpackage

// File: rtl/flow_hash.sv
module flow_hash
  import flow_lookup_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  key_t             key_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [15:0] crc;

  always_comb crc = crc16(key_i);

  generate
    if (IDX_W >= 16) begin : g_wide
      assign idx_o = IDX_W'(crc);
    end else begin : g_narrow
      assign idx_o = crc[IDX_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/flow_table.sv
module flow_table #(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 136,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DEPTH-1:0]  vld_q;
  logic [DATA_W-1:0] mem_q [DEPTH];

  // valid bits reset, payload does not
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else if (wr_en_i) vld_q[wr_addr_i] <= wr_valid_i;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  assign rd_valid_o = vld_q[rd_addr_i];
  assign rd_data_o  = mem_q[rd_addr_i];
endmodule

// File: rtl/flow_walk.sv
module flow_walk
  import flow_lookup_pkg::*;
#(
  parameter int IDX_W    = 8,
  parameter int HINT_W   = 8,
  parameter int SID_W    = 16,
  parameter int NH_W     = 8,
  parameter int MAX_HOPS = 4,
  localparam int ENT_W   = KEY_W + SID_W + NH_W + HINT_W,
  localparam int HOP_W   = $clog2(MAX_HOPS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  key_t              req_key_i,
  input  logic [IDX_W-1:0]  req_idx_i,
  input  logic [NH_W-1:0]   miss_nh_i,
  output logic [IDX_W-1:0]  pri_addr_o,
  input  logic              pri_vld_i,
  input  logic [ENT_W-1:0]  pri_data_i,
  output logic [HINT_W-1:0] ovf_addr_o,
  input  logic              ovf_vld_i,
  input  logic [ENT_W-1:0]  ovf_data_i,
  output logic              res_valid_o,
  output logic              res_hit_o,
  output logic [SID_W-1:0]  res_sid_o,
  output logic [NH_W-1:0]   res_nh_o
);
  walk_st_e          st_q;
  key_t              key_q;
  logic [IDX_W-1:0]  idx_q;
  logic [HINT_W-1:0] ptr_q;
  logic [HOP_W-1:0]  hops_q;

  logic [ENT_W-1:0]  cur_data;
  logic              cur_vld;
  logic              cur_match;
  logic [HINT_W-1:0] cur_next;
  logic [SID_W-1:0]  cur_sid;
  logic [NH_W-1:0]   cur_nh;
  logic              may_hop;

  always_comb begin
    cur_data  = (st_q == ST_OVF) ? ovf_data_i : pri_data_i;
    cur_vld   = (st_q == ST_OVF) ? ovf_vld_i  : pri_vld_i;
    cur_match = cur_vld && (cur_data[ENT_W-1 -: KEY_W] == key_q);
    // invalid entry ends the chain whatever its hint holds
    cur_next  = cur_vld ? cur_data[HINT_W-1:0] : '0;
    cur_sid   = cur_data[HINT_W+NH_W +: SID_W];
    cur_nh    = cur_data[HINT_W +: NH_W];
    may_hop   = (st_q == ST_PRI) || (hops_q < HOP_W'(MAX_HOPS));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      key_q     <= '0;
      idx_q     <= '0;
      ptr_q     <= '0;
      hops_q    <= '0;
      res_hit_o <= 1'b0;
      res_sid_o <= '0;
      res_nh_o  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          key_q <= req_key_i;
          idx_q <= req_idx_i;
          st_q  <= ST_PRI;
        end
        ST_PRI, ST_OVF: begin
          if (cur_match) begin
            res_hit_o <= 1'b1;
            res_sid_o <= cur_sid;
            res_nh_o  <= cur_nh;
            st_q      <= ST_DONE;
          end else if (cur_next != '0 && may_hop) begin
            ptr_q  <= cur_next;
            hops_q <= (st_q == ST_PRI) ? HOP_W'(1) : hops_q + HOP_W'(1);
            st_q   <= ST_OVF;
          end else begin
            res_hit_o <= 1'b0;
            res_sid_o <= '0;
            res_nh_o  <= miss_nh_i;
            st_q      <= ST_DONE;
          end
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign res_valid_o = (st_q == ST_DONE);
  assign pri_addr_o  = idx_q;
  assign ovf_addr_o  = ptr_q;
endmodule

// File: rtl/flow_lookup.sv
module flow_lookup
  import flow_lookup_pkg::*;
#(
  parameter int PRI_DEPTH = 256,
  parameter int HINT_W    = 8,
  parameter int SID_W     = 16,
  parameter int NH_W      = 8,
  parameter int MAX_HOPS  = 4,
  localparam int PIDX_W   = $clog2(PRI_DEPTH),
  localparam int OVF_DEPTH = 1 << HINT_W,
  localparam int ENT_W    = KEY_W + SID_W + NH_W + HINT_W,
  localparam int ADDR_W   = (PIDX_W > HINT_W) ? PIDX_W : HINT_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic [IP_W-1:0]     req_src_ip_i,
  input  logic [IP_W-1:0]     req_dst_ip_i,
  input  logic [PORT_W-1:0]   req_src_port_i,
  input  logic [PORT_W-1:0]   req_dst_port_i,
  input  logic [PROTO_W-1:0]  req_proto_i,
  input  logic [NH_W-1:0]     miss_nh_i,
  input  logic                wr_en_i,
  input  logic                wr_ovf_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic                wr_valid_i,
  input  logic [KEY_W-1:0]    wr_key_i,
  input  logic [SID_W-1:0]    wr_sid_i,
  input  logic [NH_W-1:0]     wr_nh_i,
  input  logic [HINT_W-1:0]   wr_hint_i,
  output logic                res_valid_o,
  output logic                res_hit_o,
  output logic [SID_W-1:0]    res_sid_o,
  output logic [NH_W-1:0]     res_nh_o
);
  key_t              req_key;
  logic [PIDX_W-1:0] req_idx;
  logic [ENT_W-1:0]  wr_data;
  logic [PIDX_W-1:0] pri_addr;
  logic              pri_vld;
  logic [ENT_W-1:0]  pri_data;
  logic [HINT_W-1:0] ovf_addr;
  logic              ovf_vld;
  logic [ENT_W-1:0]  ovf_data;

  assign req_key = '{src_ip: req_src_ip_i, dst_ip: req_dst_ip_i,
                     src_port: req_src_port_i, dst_port: req_dst_port_i,
                     proto: req_proto_i};
  assign wr_data = {wr_key_i, wr_sid_i, wr_nh_i, wr_hint_i};

  flow_hash #(.IDX_W(PIDX_W)) u_hash (
    .key_i (req_key),
    .idx_o (req_idx)
  );

  flow_table #(.DEPTH(PRI_DEPTH), .DATA_W(ENT_W)) u_pri (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i && !wr_ovf_i),
    .wr_addr_i  (wr_addr_i[PIDX_W-1:0]),
    .wr_valid_i (wr_valid_i),
    .wr_data_i  (wr_data),
    .rd_addr_i  (pri_addr),
    .rd_valid_o (pri_vld),
    .rd_data_o  (pri_data)
  );

  flow_table #(.DEPTH(OVF_DEPTH), .DATA_W(ENT_W)) u_ovf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i && wr_ovf_i),
    .wr_addr_i  (wr_addr_i[HINT_W-1:0]),
    .wr_valid_i (wr_valid_i),
    .wr_data_i  (wr_data),
    .rd_addr_i  (ovf_addr),
    .rd_valid_o (ovf_vld),
    .rd_data_o  (ovf_data)
  );

  flow_walk #(
    .IDX_W(PIDX_W), .HINT_W(HINT_W), .SID_W(SID_W), .NH_W(NH_W), .MAX_HOPS(MAX_HOPS)
  ) u_walk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_key_i   (req_key),
    .req_idx_i   (req_idx),
    .miss_nh_i   (miss_nh_i),
    .pri_addr_o  (pri_addr),
    .pri_vld_i   (pri_vld),
    .pri_data_i  (pri_data),
    .ovf_addr_o  (ovf_addr),
    .ovf_vld_i   (ovf_vld),
    .ovf_data_i  (ovf_data),
    .res_valid_o (res_valid_o),
    .res_hit_o   (res_hit_o),
    .res_sid_o   (res_sid_o),
    .res_nh_o    (res_nh_o)
  );
endmodule

// File: rtl/flow_lookup_chk.sv
module flow_lookup_chk #(
  parameter int SID_W    = 16,
  parameter int NH_W     = 8,
  parameter int MAX_HOPS = 4,
  localparam int LAT_W   = $clog2(MAX_HOPS + 4) + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic [NH_W-1:0]  miss_nh_i,
  input logic             res_valid_o,
  input logic             res_hit_o,
  input logic [SID_W-1:0] res_sid_o,
  input logic [NH_W-1:0]  res_nh_o
);
  logic [LAT_W-1:0] lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lat_q <= '0;
    else if (req_valid_i && req_ready_o) lat_q <= LAT_W'(1);
    else if (!req_ready_o && lat_q != '1) lat_q <= lat_q + LAT_W'(1);
  end

  assert_res_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);

  assert_res_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> !req_ready_o);

  assert_accept_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  assert_ready_after_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> req_ready_o);

  assert_walk_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (lat_q >= LAT_W'(2) && lat_q <= LAT_W'(MAX_HOPS + 2)));

  assert_miss_format_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_hit_o && $stable(miss_nh_i)) |->
      (res_sid_o == '0 && res_nh_o == miss_nh_i));
endmodule

bind flow_lookup flow_lookup_chk #(
  .SID_W(SID_W), .NH_W(NH_W), .MAX_HOPS(MAX_HOPS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .miss_nh_i   (miss_nh_i),
  .res_valid_o (res_valid_o),
  .res_hit_o   (res_hit_o),
  .res_sid_o   (res_sid_o),
  .res_nh_o    (res_nh_o)
);

// File: tb/sim_flow_lookup.sv
module sim_flow_lookup;
  localparam int CLK_PERIOD = 10;
  localparam int HOPS       = 2;
  localparam logic [7:0] DFLT_NH = 8'hF0;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         req_valid_i = 1'b0;
  logic         req_ready_o;
  logic [31:0]  req_src_ip_i = '0;
  logic [31:0]  req_dst_ip_i = '0;
  logic [15:0]  req_src_port_i = '0;
  logic [15:0]  req_dst_port_i = '0;
  logic [7:0]   req_proto_i = '0;
  logic [7:0]   miss_nh_i = DFLT_NH;
  logic         wr_en_i = 1'b0;
  logic         wr_ovf_i = 1'b0;
  logic [7:0]   wr_addr_i = '0;
  logic         wr_valid_i = 1'b0;
  logic [103:0] wr_key_i = '0;
  logic [15:0]  wr_sid_i = '0;
  logic [7:0]   wr_nh_i = '0;
  logic [7:0]   wr_hint_i = '0;
  logic         res_valid_o;
  logic         res_hit_o;
  logic [15:0]  res_sid_o;
  logic [7:0]   res_nh_o;

  int n_chk = 0;
  int n_fail = 0;

  flow_lookup #(.MAX_HOPS(HOPS)) u0 (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // setup kind, key id, expected hit, expected latency in edges
  localparam logic [11:0] VEC [10] = '{
    {4'd0, 4'd1,  1'b1, 3'd1},
    {4'd1, 4'd2,  1'b1, 3'd2},
    {4'd2, 4'd3,  1'b1, 3'd3},
    {4'd3, 4'd4,  1'b0, 3'd3},
    {4'd4, 4'd5,  1'b0, 3'd1},
    {4'd5, 4'd6,  1'b0, 3'd1},
    {4'd6, 4'd7,  1'b0, 3'd2},
    {4'd7, 4'd8,  1'b1, 3'd1},
    {4'd0, 4'd9,  1'b1, 3'd1},
    {4'd1, 4'd10, 1'b1, 3'd2}
  };

  function automatic logic [103:0] mk_key(input int id);
    logic [31:0] s, d;
    s = 32'h0A000001 + 32'(id);
    d = 32'hC0A80101 + 32'(id * 7);
    return {s, d, 16'(4000 + id), 16'd443, 8'd6};
  endfunction

  function automatic logic [103:0] rev_key(input logic [103:0] k);
    return {k[71:40], k[103:72], k[23:8], k[39:24], k[7:0]};
  endfunction

  function automatic logic [7:0] bucket(input logic [103:0] k);
    logic [15:0] r;
    logic b;
    r = 16'hFFFF;
    for (int i = 0; i < 104; i++) begin
      b = r[15] ^ k[103 - i];
      r = r << 1;
      if (b) r = r ^ 16'h1021;
    end
    return r[7:0];
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit ovf, input logic [7:0] a, input bit v,
                    input logic [103:0] k, input logic [15:0] s,
                    input logic [7:0] nh, input logic [7:0] h);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_ovf_i = ovf; wr_addr_i = a; wr_valid_i = v;
    wr_key_i = k; wr_sid_i = s; wr_nh_i = nh; wr_hint_i = h;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic lookup(input logic [103:0] k, output bit hit,
                        output logic [15:0] sid, output logic [7:0] nh, output int lat);
    @(negedge clk_i);
    req_valid_i = 1'b1;
    {req_src_ip_i, req_dst_ip_i, req_src_port_i, req_dst_port_i, req_proto_i} = k;
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    lat = 0;
    while (!res_valid_o && lat < 20) begin
      @(negedge clk_i);
      lat++;
    end
    hit = res_hit_o; sid = res_sid_o; nh = res_nh_o;
  endtask

  task automatic setup(input int kind, input int id);
    logic [103:0] k, d;
    logic [7:0] b;
    k = mk_key(id); d = k ^ 104'h1; b = bucket(k);
    case (kind)
      0: wr(0, b, 1, k, 16'h0100 + 16'(id), 8'h10 + 8'(id), 8'd0);
      1: begin
        wr(0, b, 1, d, 16'h0DEA, 8'h55, 8'd5);
        wr(1, 8'd5, 1, k, 16'h0100 + 16'(id), 8'h10 + 8'(id), 8'd0);
      end
      2: begin
        wr(0, b, 1, d, 16'h0DEA, 8'h55, 8'd5);
        wr(1, 8'd5, 1, d, 16'h0DEB, 8'h56, 8'd9);
        wr(1, 8'd9, 1, k, 16'h0100 + 16'(id), 8'h10 + 8'(id), 8'd0);
      end
      3: begin
        wr(0, b, 1, d, 16'h0DEA, 8'h55, 8'd5);
        wr(1, 8'd5, 1, d, 16'h0DEB, 8'h56, 8'd9);
        wr(1, 8'd9, 1, d, 16'h0DEC, 8'h57, 8'd12);
        wr(1, 8'd12, 1, k, 16'h0100 + 16'(id), 8'h10 + 8'(id), 8'd0);
      end
      4: wr(0, b, 1, d, 16'h0DEA, 8'h55, 8'd0);
      5: begin
        wr(1, 8'd5, 1, k, 16'h0BAD, 8'h66, 8'd0);
        wr(0, b, 0, k, 16'h0100 + 16'(id), 8'h10 + 8'(id), 8'd5);
      end
      6: begin
        wr(0, b, 1, d, 16'h0DEA, 8'h55, 8'd5);
        wr(1, 8'd5, 1, d, 16'h0DEB, 8'h56, 8'd0);
      end
      default: begin
        wr(1, 8'd5, 1, k, 16'hBEEF, 8'h77, 8'd0);
        wr(0, b, 1, k, 16'h0100 + 16'(id), 8'h10 + 8'(id), 8'd5);
      end
    endcase
  endtask

  function automatic string tag_of(input int kind);
    case (kind)
      0: return "R2/R3 primary hit";
      1: return "R4 overflow hop 1";
      2: return "R4 overflow hop 2";
      3: return "R6 hop bound miss";
      4: return "R5 hint zero miss";
      5: return "R9/R5 invalid entry";
      6: return "R5 chain end miss";
      default: return "R2 primary wins over hint";
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit hit;
    logic [15:0] sid;
    logic [7:0] nh;
    int lat;
    int kind, id;
    logic [15:0] esid;
    logic [7:0] enh;

    repeat (3) @(negedge clk_i);
    check(req_ready_o == 1'b1, "R1 ready after reset", 64'(req_ready_o), 64'd1);
    check(res_valid_o == 1'b0, "R1 no result after reset", 64'(res_valid_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    lookup(mk_key(15), hit, sid, nh, lat);
    check(hit == 1'b0, "R1 empty table misses", 64'(hit), 64'd0);
    check(nh == DFLT_NH, "R1/R7 empty table redirect", 64'(nh), 64'(DFLT_NH));

    foreach (VEC[i]) begin
      kind = int'(VEC[i][11:8]);
      id   = int'(VEC[i][7:4]);
      setup(kind, id);
      lookup(mk_key(id), hit, sid, nh, lat);
      esid = VEC[i][3] ? 16'h0100 + 16'(id) : 16'h0000;
      enh  = VEC[i][3] ? 8'h10 + 8'(id) : DFLT_NH;
      check(hit == VEC[i][3], {tag_of(kind), " hit"}, 64'(hit), 64'(VEC[i][3]));
      check(sid == esid, {tag_of(kind), " sid"}, 64'(sid), 64'(esid));
      check(nh == enh, {tag_of(kind), " nh"}, 64'(nh), 64'(enh));
      check(lat == int'(VEC[i][2:0]), {tag_of(kind), " latency"}, 64'(lat),
            64'(VEC[i][2:0]));
    end

    // R7: redirect target follows the configuration input
    miss_nh_i = 8'h3C;
    setup(4, 13);
    lookup(mk_key(13), hit, sid, nh, lat);
    check(hit == 1'b0 && nh == 8'h3C, "R7 configured redirect nh", 64'(nh), 64'h3C);
    check(sid == 16'h0, "R7 miss sid zero", 64'(sid), 64'h0);
    miss_nh_i = DFLT_NH;

    // R10: forward and reverse tuple coexist
    begin
      logic [103:0] fk, rk;
      fk = mk_key(14); rk = rev_key(fk);
      if (bucket(fk) == bucket(rk)) begin
        wr(0, bucket(fk), 1, fk, 16'h0A0A, 8'hA1, 8'd7);
        wr(1, 8'd7, 1, rk, 16'h0B0B, 8'hB1, 8'd0);
      end else begin
        wr(0, bucket(fk), 1, fk, 16'h0A0A, 8'hA1, 8'd0);
        wr(0, bucket(rk), 1, rk, 16'h0B0B, 8'hB1, 8'd0);
      end
      lookup(fk, hit, sid, nh, lat);
      check(hit && sid == 16'h0A0A, "R10 forward session", 64'(sid), 64'h0A0A);
      lookup(rk, hit, sid, nh, lat);
      check(hit && sid == 16'h0B0B, "R10 reverse session", 64'(sid), 64'h0B0B);
    end

    // R8: requests while busy are ignored
    begin
      int pulses, busy_bad, cyc;
      setup(2, 11);
      setup(0, 12);
      pulses = 0; busy_bad = 0;
      @(negedge clk_i);
      req_valid_i = 1'b1;
      {req_src_ip_i, req_dst_ip_i, req_src_port_i, req_dst_port_i, req_proto_i} = mk_key(11);
      @(posedge clk_i);
      @(negedge clk_i);
      {req_src_ip_i, req_dst_ip_i, req_src_port_i, req_dst_port_i, req_proto_i} = mk_key(12);
      cyc = 0;
      while (!res_valid_o && cyc < 20) begin
        if (req_ready_o) busy_bad++;
        @(negedge clk_i);
        cyc++;
      end
      if (res_valid_o) pulses++;
      sid = res_sid_o;
      req_valid_i = 1'b0;
      for (int c = 0; c < 5; c++) begin
        @(negedge clk_i);
        if (res_valid_o) pulses++;
      end
      check(busy_bad == 0, "R8 ready low while busy", 64'(busy_bad), 64'd0);
      check(pulses == 1, "R8 single result", 64'(pulses), 64'd1);
      check(sid == 16'h010B, "R8 first request served", 64'(sid), 64'h010B);
      check(req_ready_o == 1'b1, "R8 ready after result", 64'(req_ready_o), 64'd1);
    end

    // R9: deleting an entry stops it matching
    setup(0, 1);
    wr(0, bucket(mk_key(1)), 0, mk_key(1), 16'h0101, 8'h11, 8'd0);
    lookup(mk_key(1), hit, sid, nh, lat);
    check(hit == 1'b0 && nh == DFLT_NH, "R9 deleted entry misses", 64'(hit), 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule